// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the processor-side state machine that runs one bus cycle on a bus where address and data share the same lines. A cycle starts when the requester hands over a command: the direction, the access width and the address. The block then walks through numbered timing states. It strobes the address in the first state. It turns the bus around. It then sits in the data state until the memory side reports ready, and after that it returns to idle. Throughout the cycle, a T-state counter tells the rest of the core how far the cycle has progressed.

The block has two modes, and the mode is fixed when reset is released. In translated mode, every cycle gains one extra state in which an external translation unit works. That unit may raise a float request to freeze the cycle. While the cycle is frozen, the T-state count does not advance and the direction line is released. The cycle resumes at the same point once the float request is withdrawn. In untranslated mode there is no extra state, and the block drives a data strobe during the data state.

The command interface is valid/ready. `req_ready_o` is high only while the sequencer is idle, and a command is taken on a clock edge where both valid and ready are high. The requester must hold the command fields stable while valid is high and ready is low. Back-pressure lasts for the whole of a cycle, including its wait and float states.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `req_ready_o`=1, `tstate_o`=0, address strobe, data strobe and direction enable are 0, and `hbe_n_o`=1.
- R2: A command is accepted only when `req_ready_o` is high. `req_ready_o` is low for the whole cycle, and a valid held during a cycle changes neither direction nor length.
- R3: `addr_stb_o` is high for exactly one clock, the first one after acceptance, when `tstate_o`=1. `addr_o` then shows the accepted address.
- R4: The mode is captured from `xlat_n_i` on the last clock edge while `rst_n` is low: 0 selects translated mode and 1 selects untranslated mode. Later changes of `xlat_n_i` have no effect until the next reset.
- R5: `tstate_o` is 1 in the first state and rises by one on each clock of the cycle. It saturates at its maximum (15 by default) and returns to 0 when the cycle ends.
- R6: In translated mode, state 2 is the translation state. While `float_i` is high there, the state and `tstate_o` hold. With no float and no waits, a translated cycle lasts 4 clocks and an untranslated one lasts 3. In untranslated mode `float_i` has no effect.
- R7: `dir_oe_o` is 0 exactly in the clocks where the cycle is frozen by a float, and 1 in every other clock of the cycle.
- R8: In translated mode `data_stb_o` is never asserted.
- R9: In untranslated mode `data_stb_o` is high only in the data state (from `tstate_o`=3 up to and including the ready clock). It is low in the address and turnaround states.
- R10: The cycle ends on the clock edge where `rdy_i` is high in the data state. `rdy_i` seen in earlier states is ignored, and each clock in the data state without ready adds one wait clock.
- R11: `dir_o` is 0 for a read and 1 for a write, and is held for the whole cycle.
- R12: `hbe_n_o` (active low) is 0 for a word access, and for a byte access to an odd address (address bit 0 = 1). It is 1 for a byte access to an even address and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge starts a T-state |
| rst_n | input | 1 | Active-low reset |
| xlat_n_i | input | 1 | Mode select, sampled during reset; 0 = translated |
| req_valid_i | input | 1 | Command valid |
| req_ready_o | output | 1 | Sequencer idle, command can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_addr_i | input | ADDR_W | Byte address of the command |
| float_i | input | 1 | Freeze request from the translation unit |
| rdy_i | input | 1 | Active-high cycle-complete indication |
| addr_o | output | ADDR_W | Address of the cycle in progress |
| addr_stb_o | output | 1 | Address strobe, first T-state only |
| data_stb_o | output | 1 | Data strobe, untranslated data state only |
| dir_o | output | 1 | Direction, 0 = read, 1 = write |
| dir_oe_o | output | 1 | Output enable of the direction line |
| hbe_n_o | output | 1 | High-byte enable, active low |
| tstate_o | output | TS_W | Current T-state number, 0 when idle |

## Verification
The hardest situation to reach is a float lasting several clocks inside the translation state, followed by wait states. In that case the T-state count must freeze and then resume, and the total cycle length must equal the non-frozen count plus the frozen clocks. Each table vector first resets the block with the desired mode. The bench then watches `tstate_o` at each falling edge: it raises `float_i` while the count reads 2, and raises `rdy_i` once enough unfrozen clocks have passed. This places the float and the waits at exact points. The same loop drives float into untranslated cycles and raises ready too early, so that both can be shown to be ignored.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_XLAT = 3'd2,
    ST_TURN = 3'd3,
    ST_DATA = 3'd4
  } seq_state_e;
endpackage

// File: rtl/bus_seq_mode.sv
module bus_seq_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic xlat_n_i,
  output logic xlat_o
);
  logic xlat_q;

  // captured on every edge while reset is held; frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) xlat_q <= ~xlat_n_i;
  end

  assign xlat_o = xlat_q;

  // R4
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(xlat_q));
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int TS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xlat_i,
  input  logic            start_i,
  input  logic            float_i,
  input  logic            rdy_i,
  output seq_state_e      state_o,
  output logic [TS_W-1:0] tstate_o
);
  localparam logic [TS_W-1:0] TS_MAX = '1;
  localparam logic [TS_W-1:0] TS_ONE = TS_W'(1);

  seq_state_e st_q, st_d;
  logic [TS_W-1:0] ts_q, ts_d;
  logic frozen, finish;

  assign frozen = (st_q == ST_XLAT) && float_i;
  assign finish = (st_q == ST_DATA) && rdy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ADDR;
      ST_ADDR: st_d = xlat_i ? ST_XLAT : ST_TURN;
      ST_XLAT: if (!float_i) st_d = ST_TURN;
      ST_TURN: st_d = ST_DATA;
      ST_DATA: if (rdy_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ts_d = ts_q;
    if (st_q == ST_IDLE) begin
      if (start_i) ts_d = TS_ONE;
    end else if (finish) begin
      ts_d = '0;
    end else if (!frozen && ts_q != TS_MAX) begin
      ts_d = ts_q + TS_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ts_q <= '0;
    end else begin
      st_q <= st_d;
      ts_q <= ts_d;
    end
  end

  assign state_o  = st_q;
  assign tstate_o = ts_q;

  // R6
  float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XLAT && float_i) |=> (st_q == ST_XLAT && ts_q == $past(ts_q)));
  // R10
  ready_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && rdy_i) |=> (st_q == ST_IDLE && ts_q == '0));
  // R6
  xlat_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_i |-> st_q != ST_XLAT);
endmodule

// File: rtl/bus_seq_decode.sv
module bus_seq_decode
  import bus_seq_pkg::*;
(
  input  seq_state_e st_i,
  input  logic       xlat_i,
  input  logic       float_i,
  input  logic       word_i,
  input  logic       addr0_i,
  output logic       addr_stb_o,
  output logic       data_stb_o,
  output logic       dir_oe_o,
  output logic       hbe_n_o
);
  logic active;

  assign active     = (st_i != ST_IDLE);
  assign addr_stb_o = (st_i == ST_ADDR);
  assign data_stb_o = !xlat_i && (st_i == ST_DATA);
  assign dir_oe_o   = active && !(st_i == ST_XLAT && float_i);
  assign hbe_n_o    = !(active && (word_i || addr0_i));

  // R12
  word_hbe_chk: assert final (!(active && word_i) || !hbe_n_o);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_n_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              float_i,
  input  logic              rdy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_stb_o,
  output logic              data_stb_o,
  output logic              dir_o,
  output logic              dir_oe_o,
  output logic              hbe_n_o,
  output logic [TS_W-1:0]   tstate_o
);
  seq_state_e st;
  logic xlat, accept;
  logic wr_q, word_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready_o = (st == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  bus_seq_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .xlat_n_i (xlat_n_i),
    .xlat_o   (xlat)
  );

  bus_seq_fsm #(.TS_W(TS_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .xlat_i   (xlat),
    .start_i  (accept),
    .float_i  (float_i),
    .rdy_i    (rdy_i),
    .state_o  (st),
    .tstate_o (tstate_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write_i;
      word_q <= req_word_i;
      addr_q <= req_addr_i;
    end
  end

  bus_seq_decode u_dec (
    .st_i       (st),
    .xlat_i     (xlat),
    .float_i    (float_i),
    .word_i     (word_q),
    .addr0_i    (addr_q[0]),
    .addr_stb_o (addr_stb_o),
    .data_stb_o (data_stb_o),
    .dir_oe_o   (dir_oe_o),
    .hbe_n_o    (hbe_n_o)
  );

  assign addr_o = addr_q;
  assign dir_o  = wr_q;

  // R3
  astb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb_o |-> tstate_o == TS_W'(1));
  // R8
  no_dstb_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlat |-> !data_stb_o);
  // R11
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate_o != '0 && $past(tstate_o) != '0) |-> $stable(dir_o));
  // R7
  oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate_o != '0 && !dir_oe_o) |-> float_i);
  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> tstate_o == '0);
endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  localparam int ADDR_W = 24;
  localparam int TS_W   = 4;
  localparam int NVEC   = 9;
  // fields: [11] translated [10] write [9] word [8] addr bit0 [7] early ready
  //         [6:4] float clocks [3:0] wait clocks
  localparam logic [11:0] VECS [NVEC] = '{
    12'b0_0_0_0_0_000_0000,
    12'b0_1_1_0_0_000_0010,
    12'b1_0_0_1_0_000_0000,
    12'b1_1_1_0_0_011_0001,
    12'b1_0_0_0_1_010_0000,
    12'b0_1_0_1_1_000_0000,
    12'b0_0_1_0_0_000_1110,
    12'b1_0_0_1_0_001_0011,
    12'b0_1_1_0_0_010_0001
  };

  logic clk = 1'b0, rst_n = 1'b0, xlat_n_i = 1'b1;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_word_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic float_i = 1'b0, rdy_i = 1'b0;
  logic req_ready_o, addr_stb_o, data_stb_o, dir_o, dir_oe_o, hbe_n_o;
  logic [ADDR_W-1:0] addr_o;
  logic [TS_W-1:0] tstate_o;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u0 (
    .clk(clk), .rst_n(rst_n), .xlat_n_i(xlat_n_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_word_i(req_word_i), .req_addr_i(req_addr_i),
    .float_i(float_i), .rdy_i(rdy_i), .addr_o(addr_o),
    .addr_stb_o(addr_stb_o), .data_stb_o(data_stb_o), .dir_o(dir_o),
    .dir_oe_o(dir_oe_o), .hbe_n_o(hbe_n_o), .tstate_o(tstate_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic xn);
    @(negedge clk);
    rst_n = 1'b0; xlat_n_i = xn; float_i = 1'b0; rdy_i = 1'b0; req_valid_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic [11:0] v, input bit flip, input int idx);
    int xl, wt, nf, cyc, stall, fd, ascnt, dscnt, oecnt, last_ts, exp_ts, dirbad;
    bit done, fl;
    logic [ADDR_W-1:0] a;
    xl = int'(v[11]); nf = int'(v[6:4]); wt = int'(v[3:0]);
    do_reset(~v[11]);
    if (flip) xlat_n_i = v[11];
    a = ADDR_W'(24'h3A5C10 + idx * 2) | ADDR_W'(v[8]);
    req_valid_i = 1'b1; req_write_i = v[10]; req_word_i = v[9]; req_addr_i = a;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    cyc = 0; stall = 0; fd = 0; ascnt = 0; dscnt = 0; oecnt = 0; last_ts = 0; dirbad = 0;
    done = 1'b0;
    while (!done && cyc < 60) begin
      cyc++;
      fl = (tstate_o == TS_W'(2)) && (fd < nf);
      if (fl) fd++;
      float_i = fl;
      if (fl && xl == 1) stall++;
      rdy_i = v[7] || ((cyc - stall) >= 3 + xl + wt);
      #1;
      if (addr_stb_o) ascnt++;
      if (data_stb_o) dscnt++;
      if (!dir_oe_o) oecnt++;
      if (dir_o !== v[10]) dirbad++;
      if (cyc == 1) begin
        chk(addr_stb_o === 1'b1 && tstate_o == TS_W'(1), "R3 addr strobe in T1", int'(addr_stb_o), 1);
        chk(addr_o === a, "R3 address", int'(addr_o), int'(a));
        chk(hbe_n_o === ~(v[9] | v[8]), "R12 high byte enable", int'(hbe_n_o), int'(~(v[9] | v[8])));
        chk(req_ready_o === 1'b0, "R2 busy", int'(req_ready_o), 0);
      end
      if (cyc == 2)
        chk(data_stb_o === 1'b0, "R9 no data strobe before data state", int'(data_stb_o), 0);
      last_ts = int'(tstate_o);
      @(posedge clk);
      @(negedge clk);
      if (tstate_o == '0) done = 1'b1;
    end
    float_i = 1'b0; rdy_i = 1'b0;
    exp_ts = (3 + xl + wt > 15) ? 15 : 3 + xl + wt;
    chk(cyc == 3 + xl + wt + xl * nf, "R6 R10 cycle length", cyc, 3 + xl + wt + xl * nf);
    chk(last_ts == exp_ts, "R5 final T-state", last_ts, exp_ts);
    chk(ascnt == 1, "R3 strobe count", ascnt, 1);
    chk(dscnt == (xl == 1 ? 0 : 1 + wt), "R8 R9 data strobe clocks", dscnt, xl == 1 ? 0 : 1 + wt);
    chk(oecnt == xl * nf, "R7 direction released clocks", oecnt, xl * nf);
    chk(dirbad == 0, "R11 direction held", dirbad, 0);
    chk(req_ready_o === 1'b1 && hbe_n_o === 1'b1, "R1 idle after cycle", int'(req_ready_o), 1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b1);
    #1;
    chk(req_ready_o === 1'b1, "R1 ready", int'(req_ready_o), 1);
    chk(tstate_o == '0, "R1 tstate", int'(tstate_o), 0);
    chk(addr_stb_o === 1'b0 && data_stb_o === 1'b0, "R1 strobes", int'(addr_stb_o), 0);
    chk(dir_oe_o === 1'b0 && hbe_n_o === 1'b1, "R1 enables", int'(dir_oe_o), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0, i);

    // R4: mode input flipped after reset; untranslated cycle must still be 3 clocks
    run_vec(12'b0_0_0_0_0_000_0000, 1'b1, 20);
    // R4: translated mode kept after flip
    run_vec(12'b1_1_0_1_0_000_0000, 1'b1, 21);

    // R2: valid held during a busy cycle
    do_reset(1'b1);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_word_i = 1'b1; req_addr_i = 24'h000100;
    @(posedge clk);
    @(negedge clk);
    req_write_i = 1'b1; req_addr_i = 24'h000201;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(dir_o === 1'b0 && addr_o == 24'h000100, "R2 command not replaced", int'(dir_o), 0);
    chk(tstate_o == TS_W'(2), "R2 cycle not restarted", int'(tstate_o), 2);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0; rdy_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdy_i = 1'b0;
    #1;
    chk(tstate_o == '0 && req_ready_o === 1'b1, "R10 ended on ready", int'(tstate_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk(tstate_o == '0, "R2 no extra cycle", int'(tstate_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule